// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the per-source state for a bank of sixteen interrupt sources and decides when a source should be offered to the downstream presentation controller. For each source it holds a priority, a target server, a level/message type flag, a two-bit presented/queued state, a resend flag and a masked-pending flag. Triggers, end-of-interrupt commands, configuration writes and resend sweeps all come in through one request port. A small sequencer handles them one at a time.

A delivery offer carries the source number, its priority and its server. The offer stays up until the presentation controller answers. The answer either accepts or refuses the offer. An accepting answer may also name a source that was displaced by the new one. A refused source is marked for a later sweep. A displaced source is offered again at once, unless its number is the inter-processor source number. A source that is masked when it would be offered is not lost: it is marked pending, and it is offered again when its mask is lifted.

Top module: `isc_top`

## Requirements
- R1: After synchronous reset, every source has priority 0xFF (masked), server 0, message type, state bits 00 and both flags clear; `busy` and `dlv_valid` are low.
- R2: A trigger on a message-type source sets the state to {old bit0, 1}, with bit 0 as presented and bit 1 as queued. A delivery attempt follows only when the result is exactly 01.
- R3: An end-of-interrupt on a message-type source shifts the state right by one. Queued moves into presented and queued clears. A delivery attempt follows when presented is then set.
- R4: A trigger on a level-type source sets presented and makes an attempt only if presented was clear. An end-of-interrupt on a level-type source leaves the state unchanged and makes an attempt if presented is set.
- R5: A delivery attempt for a source whose priority is 0xFF produces no offer and sets its masked-pending flag. This holds for first attempts, sweep attempts and displaced-source attempts alike.
- R6: A configuration write that changes a source from 0xFF to any other priority while its masked-pending flag is set clears that flag and makes a delivery attempt with the new settings.
- R7: A refused offer sets the source's resend flag. A sweep visits the sources in ascending index order, clears each set resend flag, and makes an attempt for that source.
- R8: When an accepted offer reports a displaced source, that source is attempted next, unless its number equals the inter-processor source number (0 by default), which is never re-attempted.
- R9: While `dlv_valid` is high and no answer has arrived, the source, priority and server on the offer stay constant. They equal the source's configured values.
- R10: `busy` is high from the cycle after an accepted request until all the work that request causes is finished. A new request is given only while `busy` is low. Opcodes: 0 trigger, 1 end-of-interrupt, 2 sweep, 3 configure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, valid when busy is low |
| req_op | input | 2 | 0 trigger, 1 EOI, 2 sweep, 3 configure |
| req_src | input | 4 | Source index for the request |
| req_prio | input | 8 | New priority (configure only) |
| req_server | input | 4 | New server (configure only) |
| req_lsi | input | 1 | New type, 1 = level (configure only) |
| busy | output | 1 | Request in progress |
| dlv_valid | output | 1 | Delivery offer pending |
| dlv_src | output | 4 | Offered source |
| dlv_prio | output | 8 | Offered priority |
| dlv_server | output | 4 | Offered target server |
| rsp_valid | input | 1 | Answer to the offer |
| rsp_accept | input | 1 | 1 = accepted, 0 = refused |
| rsp_bump_valid | input | 1 | Accepted offer displaced a source |
| rsp_bump_src | input | 4 | Displaced source number |

## Verification
Some properties are checked on every cycle. No offer ever carries the masked priority. An offer holds steady until it is answered. A refusal always leaves the resend flag set. A displaced inter-processor number never starts a new attempt. A source can hold masked-pending only while it is masked. The bench scenarios show what no single-cycle property can: message triggers coalescing into the queued bit, the queued bit turning into a second offer on end-of-interrupt, level sources being offered again, and a masked event surviving until unmask. They also show sweeps re-offering refused sources in index order, and a displaced source being offered right after the offer that displaced it.

// File: rtl/isc_pkg.sv
package isc_pkg;

    localparam int PRIO_W = 8;
    localparam logic [PRIO_W-1:0] PRIO_MASKED = '1;
    localparam logic [1:0] PQ_P = 2'b01;

    typedef enum logic [1:0] {
        OP_TRIG  = 2'd0,
        OP_EOI   = 2'd1,
        OP_SWEEP = 2'd2,
        OP_CFG   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TRY,
        ST_WAIT,
        ST_SCAN
    } st_e;

    // state after a trigger: level sets presented, message shifts up and presents
    function automatic logic [1:0] pq_on_trigger(input logic lsi, input logic [1:0] pq);
        return lsi ? (pq | PQ_P) : {pq[0], 1'b1};
    endfunction

    // state after end-of-interrupt: level keeps state, message drains queued into presented
    function automatic logic [1:0] pq_on_eoi(input logic lsi, input logic [1:0] pq);
        return lsi ? pq : {1'b0, pq[1]};
    endfunction

endpackage

// File: rtl/isc_src_bank.sv
module isc_src_bank
    import isc_pkg::*;
#(
    parameter int N_SRC = 16,
    parameter int SRV_W = 4,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [IDX_W-1:0]              cfg_idx,
    input  logic [PRIO_W-1:0]             cfg_prio,
    input  logic [SRV_W-1:0]              cfg_server,
    input  logic                          cfg_lsi,
    input  logic                          pq_we,
    input  logic [IDX_W-1:0]              pq_idx,
    input  logic [1:0]                    pq_val,
    input  logic                          rs_set,
    input  logic                          rs_clr,
    input  logic [IDX_W-1:0]              rs_idx,
    input  logic                          mp_set,
    input  logic                          mp_clr,
    input  logic [IDX_W-1:0]              mp_idx,
    output logic [N_SRC-1:0][PRIO_W-1:0]  prio_o,
    output logic [N_SRC-1:0][SRV_W-1:0]   server_o,
    output logic [N_SRC-1:0]              lsi_o,
    output logic [N_SRC-1:0][1:0]         pq_o,
    output logic [N_SRC-1:0]              rs_o,
    output logic [N_SRC-1:0]              mp_o
);

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);

        always_ff @(posedge clk) begin
            if (rst) begin
                prio_o[g]   <= PRIO_MASKED;
                server_o[g] <= '0;
                lsi_o[g]    <= 1'b0;
                pq_o[g]     <= 2'b00;
                rs_o[g]     <= 1'b0;
                mp_o[g]     <= 1'b0;
            end else begin
                if (cfg_we && cfg_idx == MY_IDX) begin
                    prio_o[g]   <= cfg_prio;
                    server_o[g] <= cfg_server;
                    lsi_o[g]    <= cfg_lsi;
                end
                if (pq_we && pq_idx == MY_IDX) pq_o[g] <= pq_val;
                if (rs_idx == MY_IDX) begin
                    if (rs_set)      rs_o[g] <= 1'b1;
                    else if (rs_clr) rs_o[g] <= 1'b0;
                end
                if (mp_idx == MY_IDX) begin
                    if (mp_set)      mp_o[g] <= 1'b1;
                    else if (mp_clr) mp_o[g] <= 1'b0;
                end
            end
        end

        // R5
        mpend_only_masked_chk: assert property (@(posedge clk) disable iff (rst)
            mp_o[g] |-> prio_o[g] == PRIO_MASKED);
    end

endmodule

// File: rtl/isc_ctrl.sv
module isc_ctrl
    import isc_pkg::*;
#(
    parameter int N_SRC = 16,
    parameter int SRV_W = 4,
    parameter int IPI_SRC = 0,
    localparam int IDX_W = $clog2(N_SRC),
    localparam int SCAN_W = IDX_W + 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic [1:0]                    req_op,
    input  logic [IDX_W-1:0]              req_src,
    input  logic [PRIO_W-1:0]             req_prio,
    input  logic                          rsp_valid,
    input  logic                          rsp_accept,
    input  logic                          rsp_bump_valid,
    input  logic [IDX_W-1:0]              rsp_bump_src,
    input  logic [N_SRC-1:0][PRIO_W-1:0]  prio_i,
    input  logic [N_SRC-1:0][SRV_W-1:0]   server_i,
    input  logic [N_SRC-1:0]              lsi_i,
    input  logic [N_SRC-1:0][1:0]         pq_i,
    input  logic [N_SRC-1:0]              rs_i,
    input  logic [N_SRC-1:0]              mp_i,
    output logic                          cfg_we,
    output logic                          pq_we,
    output logic [1:0]                    pq_val,
    output logic                          rs_set,
    output logic                          rs_clr,
    output logic [IDX_W-1:0]              rs_idx,
    output logic                          mp_set,
    output logic                          mp_clr,
    output logic [IDX_W-1:0]              mp_idx,
    output logic                          busy,
    output logic                          dlv_valid,
    output logic [IDX_W-1:0]              dlv_src,
    output logic [PRIO_W-1:0]             dlv_prio,
    output logic [SRV_W-1:0]              dlv_server
);

    localparam logic [IDX_W-1:0]  IPI_IDX  = IDX_W'(IPI_SRC);
    localparam logic [SCAN_W-1:0] SCAN_END = SCAN_W'(N_SRC);

    st_e               st_q, st_n;
    logic [IDX_W-1:0]  cur_q, cur_n;
    logic [SCAN_W-1:0] scan_q, scan_n;
    logic              sweep_q, sweep_n;
    logic              go;
    st_e               done_st;
    logic [IDX_W-1:0]  scan_idx;

    assign scan_idx = scan_q[IDX_W-1:0];
    assign done_st  = sweep_q ? ST_SCAN : ST_IDLE;

    always_comb begin
        st_n    = st_q;
        cur_n   = cur_q;
        scan_n  = scan_q;
        sweep_n = sweep_q;
        go      = 1'b0;
        cfg_we  = 1'b0;
        pq_we   = 1'b0;
        pq_val  = pq_i[req_src];
        rs_set  = 1'b0;
        rs_clr  = 1'b0;
        rs_idx  = cur_q;
        mp_set  = 1'b0;
        mp_clr  = 1'b0;
        mp_idx  = cur_q;
        unique case (st_q)
            ST_IDLE: if (req_valid) begin
                unique case (op_e'(req_op))
                    OP_TRIG: begin
                        pq_we  = 1'b1;
                        pq_val = pq_on_trigger(lsi_i[req_src], pq_i[req_src]);
                        go     = lsi_i[req_src] ? !pq_i[req_src][0] : (pq_val == PQ_P);
                    end
                    OP_EOI: begin
                        pq_we  = 1'b1;
                        pq_val = pq_on_eoi(lsi_i[req_src], pq_i[req_src]);
                        go     = pq_val[0];
                    end
                    OP_SWEEP: begin
                        scan_n  = '0;
                        sweep_n = 1'b1;
                        st_n    = ST_SCAN;
                    end
                    OP_CFG: begin
                        cfg_we = 1'b1;
                        if (prio_i[req_src] == PRIO_MASKED && req_prio != PRIO_MASKED
                            && mp_i[req_src]) begin
                            mp_clr = 1'b1;
                            mp_idx = req_src;
                            go     = 1'b1;
                        end
                    end
                endcase
                if (go) begin
                    cur_n = req_src;
                    st_n  = ST_TRY;
                end
            end
            ST_TRY: begin
                if (prio_i[cur_q] == PRIO_MASKED) begin
                    mp_set = 1'b1;
                    st_n   = done_st;
                end else begin
                    st_n = ST_WAIT;
                end
            end
            ST_WAIT: if (rsp_valid) begin
                if (!rsp_accept) begin
                    rs_set = 1'b1;
                    st_n   = done_st;
                end else if (rsp_bump_valid && rsp_bump_src != IPI_IDX) begin
                    cur_n = rsp_bump_src;
                    st_n  = ST_TRY;
                end else begin
                    st_n = done_st;
                end
            end
            ST_SCAN: begin
                if (scan_q == SCAN_END) begin
                    sweep_n = 1'b0;
                    st_n    = ST_IDLE;
                end else begin
                    scan_n = scan_q + 1'b1;
                    if (rs_i[scan_idx]) begin
                        rs_clr = 1'b1;
                        rs_idx = scan_idx;
                        cur_n  = scan_idx;
                        st_n   = ST_TRY;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            cur_q   <= '0;
            scan_q  <= '0;
            sweep_q <= 1'b0;
        end else begin
            st_q    <= st_n;
            cur_q   <= cur_n;
            scan_q  <= scan_n;
            sweep_q <= sweep_n;
        end
    end

    assign busy       = (st_q != ST_IDLE);
    assign dlv_valid  = (st_q == ST_WAIT);
    assign dlv_src    = cur_q;
    assign dlv_prio   = prio_i[cur_q];
    assign dlv_server = server_i[cur_q];

    // R5
    masked_no_offer_chk: assert property (@(posedge clk) disable iff (rst)
        dlv_valid |-> dlv_prio != PRIO_MASKED);

    // R9
    offer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid && !rsp_valid) |=> (dlv_valid && $stable(dlv_src)
                                       && $stable(dlv_prio) && $stable(dlv_server)));

    // R7
    refuse_marks_chk: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid && rsp_valid && !rsp_accept) |=> rs_i[$past(dlv_src)]);

    // R8
    ipi_no_retry_chk: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid && rsp_valid && rsp_accept && rsp_bump_valid && rsp_bump_src == IPI_IDX)
        |=> st_q != ST_TRY);

    // R10
    sweep_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && req_op == OP_SWEEP) |=> busy);

endmodule

// File: rtl/isc_top.sv
module isc_top
    import isc_pkg::*;
#(
    parameter int N_SRC = 16,
    parameter int SRV_W = 4,
    parameter int IPI_SRC = 0,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [IDX_W-1:0]  req_src,
    input  logic [PRIO_W-1:0] req_prio,
    input  logic [SRV_W-1:0]  req_server,
    input  logic              req_lsi,
    output logic              busy,
    output logic              dlv_valid,
    output logic [IDX_W-1:0]  dlv_src,
    output logic [PRIO_W-1:0] dlv_prio,
    output logic [SRV_W-1:0]  dlv_server,
    input  logic              rsp_valid,
    input  logic              rsp_accept,
    input  logic              rsp_bump_valid,
    input  logic [IDX_W-1:0]  rsp_bump_src
);

    logic [N_SRC-1:0][PRIO_W-1:0] prio_w;
    logic [N_SRC-1:0][SRV_W-1:0]  server_w;
    logic [N_SRC-1:0]             lsi_w;
    logic [N_SRC-1:0][1:0]        pq_w;
    logic [N_SRC-1:0]             rs_w;
    logic [N_SRC-1:0]             mp_w;
    logic                         cfg_we, pq_we, rs_set, rs_clr, mp_set, mp_clr;
    logic [1:0]                   pq_val;
    logic [IDX_W-1:0]             rs_idx, mp_idx;

    isc_src_bank #(.N_SRC(N_SRC), .SRV_W(SRV_W)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_idx    (req_src),
        .cfg_prio   (req_prio),
        .cfg_server (req_server),
        .cfg_lsi    (req_lsi),
        .pq_we      (pq_we),
        .pq_idx     (req_src),
        .pq_val     (pq_val),
        .rs_set     (rs_set),
        .rs_clr     (rs_clr),
        .rs_idx     (rs_idx),
        .mp_set     (mp_set),
        .mp_clr     (mp_clr),
        .mp_idx     (mp_idx),
        .prio_o     (prio_w),
        .server_o   (server_w),
        .lsi_o      (lsi_w),
        .pq_o       (pq_w),
        .rs_o       (rs_w),
        .mp_o       (mp_w)
    );

    isc_ctrl #(.N_SRC(N_SRC), .SRV_W(SRV_W), .IPI_SRC(IPI_SRC)) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_op         (req_op),
        .req_src        (req_src),
        .req_prio       (req_prio),
        .rsp_valid      (rsp_valid),
        .rsp_accept     (rsp_accept),
        .rsp_bump_valid (rsp_bump_valid),
        .rsp_bump_src   (rsp_bump_src),
        .prio_i         (prio_w),
        .server_i       (server_w),
        .lsi_i          (lsi_w),
        .pq_i           (pq_w),
        .rs_i           (rs_w),
        .mp_i           (mp_w),
        .cfg_we         (cfg_we),
        .pq_we          (pq_we),
        .pq_val         (pq_val),
        .rs_set         (rs_set),
        .rs_clr         (rs_clr),
        .rs_idx         (rs_idx),
        .mp_set         (mp_set),
        .mp_clr         (mp_clr),
        .mp_idx         (mp_idx),
        .busy           (busy),
        .dlv_valid      (dlv_valid),
        .dlv_src        (dlv_src),
        .dlv_prio       (dlv_prio),
        .dlv_server     (dlv_server)
    );

endmodule

// File: tb/tb_isc_top.sv
module tb_isc_top;

    localparam int NS  = 16;
    localparam int IPI = 0;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [3:0] req_src = 4'd0;
    logic [7:0] req_prio = 8'd0;
    logic [3:0] req_server = 4'd0;
    logic       req_lsi = 1'b0;
    logic       busy, dlv_valid;
    logic [3:0] dlv_src, dlv_server;
    logic [7:0] dlv_prio;
    logic       rsp_valid = 1'b0, rsp_accept = 1'b0, rsp_bump_valid = 1'b0;
    logic [3:0] rsp_bump_src = 4'd0;

    isc_top dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_src(req_src), .req_prio(req_prio), .req_server(req_server),
        .req_lsi(req_lsi), .busy(busy), .dlv_valid(dlv_valid), .dlv_src(dlv_src),
        .dlv_prio(dlv_prio), .dlv_server(dlv_server), .rsp_valid(rsp_valid),
        .rsp_accept(rsp_accept), .rsp_bump_valid(rsp_bump_valid),
        .rsp_bump_src(rsp_bump_src)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [1:0] m_pq [NS];
    logic       m_rs [NS];
    logic       m_mp [NS];
    logic [7:0] m_prio [NS];
    logic [3:0] m_srv [NS];
    logic       m_lsi [NS];

    int pol = 1;        // 0 random, 1 accept, 2 refuse
    int pol_bump = -1;  // one-shot displaced source

    task automatic chk(input bit ok, input string tag, input string msg);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NS; i++) begin
            m_pq[i] = 2'b00; m_rs[i] = 0; m_mp[i] = 0;
            m_prio[i] = 8'hFF; m_srv[i] = 0; m_lsi[i] = 0;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
    endtask

    task automatic send(input int op, input int s, input int p, input int sv, input bit l);
        req_valid = 1'b1; req_op = 2'(op); req_src = 4'(s);
        req_prio = 8'(p); req_server = 4'(sv); req_lsi = l;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // one attempt chain: the source, then any displaced sources in order
    task automatic attempt(input int first, input string tag);
        int s = first;
        forever begin
            int n = 0;
            bit acc;
            bit bv;
            int bs;
            if (m_prio[s] == 8'hFF) begin
                m_mp[s] = 1;
                break;
            end
            while (!dlv_valid && n < 60) begin @(negedge clk); n++; end
            chk(dlv_valid && dlv_src == 4'(s) && dlv_prio == m_prio[s] && dlv_server == m_srv[s],
                tag, $sformatf("offer v=%0d src=%0d prio=%0d srv=%0d, expected src=%0d prio=%0d srv=%0d",
                dlv_valid, dlv_src, dlv_prio, dlv_server, s, m_prio[s], m_srv[s]));
            if (!dlv_valid) break;
            acc = (pol == 1) ? 1'b1 : (pol == 2) ? 1'b0 : 1'($urandom_range(0, 3) != 0);
            bv = 0; bs = 0;
            if (acc && pol_bump >= 0) begin bv = 1; bs = pol_bump; pol_bump = -1; end
            else if (acc && pol == 0 && $urandom_range(0, 3) == 0) begin
                bv = 1; bs = $urandom_range(0, NS - 1);
            end
            rsp_valid = 1'b1; rsp_accept = acc; rsp_bump_valid = bv; rsp_bump_src = 4'(bs);
            @(negedge clk);
            rsp_valid = 1'b0; rsp_accept = 1'b0; rsp_bump_valid = 1'b0;
            if (!acc) begin m_rs[s] = 1; break; end
            if (bv && bs != IPI) s = bs;
            else break;
        end
    endtask

    task automatic end_op(input string tag);
        int n = 0;
        while ((busy || dlv_valid) && n < 60) begin @(negedge clk); n++; end
        chk(!busy && !dlv_valid, tag,
            $sformatf("after request busy=%0d dlv_valid=%0d, expected 0 0", busy, dlv_valid));
        if (busy || dlv_valid) do_reset();
    endtask

    task automatic do_trig(input int s, input string tag);
        logic [1:0] o = m_pq[s];
        bit go;
        if (m_lsi[s]) begin m_pq[s] = o | 2'b01; go = !o[0]; end
        else begin m_pq[s] = {o[0], 1'b1}; go = (m_pq[s] == 2'b01); end
        send(0, s, 0, 0, 0);
        if (go) attempt(s, tag);
        end_op(tag);
    endtask

    task automatic do_eoi(input int s, input string tag);
        if (!m_lsi[s]) m_pq[s] = {1'b0, m_pq[s][1]};
        send(1, s, 0, 0, 0);
        if (m_pq[s][0]) attempt(s, tag);
        end_op(tag);
    endtask

    task automatic do_cfg(input int s, input int p, input int sv, input bit l, input string tag);
        bit un = (m_prio[s] == 8'hFF) && (p != 8'hFF) && m_mp[s];
        m_prio[s] = 8'(p); m_srv[s] = 4'(sv); m_lsi[s] = l;
        send(3, s, p, sv, l);
        if (un) begin m_mp[s] = 0; attempt(s, tag); end
        end_op(tag);
    endtask

    task automatic do_sweep(input string tag);
        send(2, 0, 0, 0, 0);
        for (int i = 0; i < NS; i++) begin
            if (m_rs[i]) begin m_rs[i] = 0; attempt(i, tag); end
        end
        end_op(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        model_reset();
        do_reset();
        // R1: idle outputs after reset; source 3 starts masked
        chk(!busy && !dlv_valid, "R1",
            $sformatf("busy=%0d dlv_valid=%0d, expected 0 0", busy, dlv_valid));
        pol = 1;
        do_trig(3, "R1");                 // masked by reset -> pending, no offer
        do_cfg(3, 10, 2, 0, "R6");        // unmask -> offer
        // R2/R3 coalescing and drain
        do_trig(3, "R2");                 // 01 -> 11, no offer
        do_trig(3, "R2");                 // 11 stays, no offer
        do_eoi(3, "R3");                  // 11 -> 01, offer
        do_eoi(3, "R3");                  // 01 -> 00, none
        do_trig(3, "R2");                 // 00 -> 01, offer
        // R4 level source
        do_cfg(5, 4, 1, 1, "R4");
        do_trig(5, "R4");
        do_trig(5, "R4");
        do_eoi(5, "R4");
        // R7 refusal and sweep order
        do_cfg(7, 20, 3, 0, "R7");
        do_cfg(9, 21, 4, 0, "R7");
        pol = 2;
        do_trig(9, "R7");
        do_trig(7, "R7");
        pol = 1;
        do_sweep("R7");
        do_sweep("R7");
        // R8 displaced source re-offered, IPI number not
        do_cfg(6, 30, 5, 0, "R8");
        do_cfg(8, 31, 6, 0, "R8");
        pol_bump = 6;
        do_trig(8, "R8");
        do_cfg(0, 1, 0, 0, "R8");
        pol_bump = IPI;
        do_trig(6, "R8");
        // R5 masked sweep retains, unmask offers
        do_cfg(11, 40, 7, 0, "R5");
        pol = 2;
        do_trig(11, "R5");
        pol = 1;
        do_cfg(11, 8'hFF, 7, 0, "R5");
        do_sweep("R5");
        do_cfg(11, 41, 8, 0, "R5");
        // randomized mix
        pol = 0;
        for (int k = 0; k < 400; k++) begin
            int s = $urandom_range(0, NS - 1);
            int r = $urandom_range(0, 9);
            if (r < 4)       do_trig(s, "R9");
            else if (r < 7)  do_eoi(s, "R9");
            else if (r < 8)  do_sweep("R10");
            else do_cfg(s, ($urandom_range(0, 3) == 0) ? 255 : $urandom_range(0, 254),
                        $urandom_range(0, 15), 1'($urandom_range(0, 1)), "R6");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule